// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This is a purely combinational execution slice for the bit-manipulation half of a small 8-bit core. It decodes the second byte of a prefixed instruction directly from its fields. From the operand value and the incoming flag nibble it produces four things: the new value, the new flags, a write-back enable and the 3-bit register selector taken from the opcode. The operations are:

- rotates, both around the carry and through the carry;
- arithmetic and logical shifts;
- nibble swap;
- single-bit test, clear and set.

A separate input, `acc_mode`, selects the short unprefixed accumulator rotates. These use the same rotate datapath, but their zero flag is always forced low.

The surrounding core reads the register that `reg_sel` names and presents its value on `operand`. It writes `result` back only when `wr_en` is high. The core also owns the memory accesses and all cycle timing.

Flags are carried as a nibble `{Z, N, H, C}`: bit 3 is Z, bit 2 is N, bit 1 is H and bit 0 is C.

Top module: `bitrot_unit`

## Requirements
- R1: When `acc_mode` is 0, `reg_sel` equals `sub_op[2:0]`. When `acc_mode` is 1, `reg_sel` is 7, the code for the accumulator.
- R2: In prefixed mode, `sub_op[7:6]`=00 selects the shift/rotate group, and `sub_op[5:3]` selects the operation. Code 0 rotates left and code 1 rotates right. In both, the bit that leaves the value goes into C and also into the vacated bit.
- R3: Code 2 rotates left through carry: old C enters bit 0 and old bit 7 goes to C. Code 3 rotates right through carry: old C enters bit 7 and old bit 0 goes to C.
- R4: Code 4 shifts left with 0 entering and old bit 7 going to C. Code 5 shifts right, keeping bit 7 and sending old bit 0 to C. Code 7 shifts right with 0 entering and old bit 0 going to C.
- R5: Code 6 exchanges the two nibbles and clears C.
- R6: For every prefixed shift/rotate-group operation, Z is 1 exactly when `result` is 0, and N and H are 0.
- R7: Group 01 (bit test, bit index `sub_op[5:3]`) does the following:
  - sets Z to the inverse of the tested bit;
  - sets H to 1 and N to 0;
  - keeps C;
  - presents the operand unchanged on `result`.
- R8: Group 10 clears, and group 11 sets, bit `sub_op[5:3]` of the operand. All other bits and all four flags pass through unchanged.
- R9: When `acc_mode` is 1, `sub_op[4:3]` picks codes 0 to 3 of R2 and R3, and all other `sub_op` bits are ignored. Z, N and H are 0, and C follows R2 or R3.
- R10: `wr_en` is 0 only for the prefixed bit-test group and 1 for every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_op | input | 8 | Sub-opcode: group [7:6], operation or bit index [5:3], register [2:0] |
| operand | input | 8 | Value read from the selected register |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| acc_mode | input | 1 | 1 selects the unprefixed accumulator rotates |
| result | output | 8 | Value to write back |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| wr_en | output | 1 | Write-back enable |
| reg_sel | output | 3 | Register selector |

## Verification
The accumulator-rotate input and a prefixed sub-opcode arrive in the same cycle whenever `acc_mode` is high. In that case the group and register fields still hold arbitrary values, including the bit-test code. The bench provokes this by randomising every `sub_op` bit while `acc_mode` is set, and by directed cases that pair `acc_mode` with a bit-test opcode and a zero result. The outcome is judged by requiring the accumulator behaviour to win: write-back enabled, register 7, Z forced to 0, and no trace of the test, clear or set path.

// File: rtl/bitrot_pkg.sv
// Package: shared widths, flag layout and operation codes for the
// rotate/shift/bit unit. Assumes an 8-bit datapath and a 4-bit flag nibble.
package bitrot_pkg;
    parameter int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int REG_W  = 3;
    localparam int GRP_W  = 2;
    localparam int FLAG_W = 4;
    localparam logic [REG_W-1:0] ACC_REG = '1;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef enum logic [GRP_W-1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_ROL  = 3'd0,
        SH_ROR  = 3'd1,
        SH_RLC  = 3'd2,
        SH_RRC  = 3'd3,
        SH_ASL  = 3'd4,
        SH_ASR  = 3'd5,
        SH_SWAP = 3'd6,
        SH_LSR  = 3'd7
    } shop_e;
endpackage

// File: rtl/bitrot_decode.sv
// Module: bitrot_decode
// Splits the sub-opcode into group, operation, bit index and register.
// Assumes the accumulator mode only uses sub_op[4:3] and always targets A.
module bitrot_decode
    import bitrot_pkg::*;
(
    input  logic [DATA_W-1:0] sub_op,
    input  logic              acc_mode,
    output grp_e              grp,
    output shop_e             shop,
    output logic [IDX_W-1:0]  bit_idx,
    output logic [REG_W-1:0]  reg_sel,
    output logic              wr_en
);
    // Field extraction; accumulator mode forces the shift group and register A.
    always_comb begin
        bit_idx = sub_op[5:3];
        if (acc_mode) begin
            grp     = GRP_SHIFT;
            shop    = shop_e'({1'b0, sub_op[4:3]});
            reg_sel = ACC_REG;
        end else begin
            grp     = grp_e'(sub_op[7:6]);
            shop    = shop_e'(sub_op[5:3]);
            reg_sel = sub_op[2:0];
        end
        wr_en = (grp != GRP_TEST);
    end
endmodule

// File: rtl/bitrot_shift.sv
// Module: bitrot_shift
// Rotates, shifts and nibble swap with flag generation.
// Assumes acc_mode selects the short accumulator form whose Z is forced low.
module bitrot_shift
    import bitrot_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  flags_t            fin,
    input  shop_e             shop,
    input  logic              acc_mode,
    output logic [DATA_W-1:0] res,
    output flags_t            fout
);
    localparam int HALF = DATA_W / 2;
    logic carry;

    // Datapath: compute the shifted value and the bit leaving it.
    always_comb begin
        unique case (shop)
            SH_ROL:  begin res = {value[DATA_W-2:0], value[DATA_W-1]};  carry = value[DATA_W-1]; end
            SH_ROR:  begin res = {value[0], value[DATA_W-1:1]};         carry = value[0];        end
            SH_RLC:  begin res = {value[DATA_W-2:0], fin.c};            carry = value[DATA_W-1]; end
            SH_RRC:  begin res = {fin.c, value[DATA_W-1:1]};            carry = value[0];        end
            SH_ASL:  begin res = {value[DATA_W-2:0], 1'b0};             carry = value[DATA_W-1]; end
            SH_ASR:  begin res = {value[DATA_W-1], value[DATA_W-1:1]};  carry = value[0];        end
            SH_SWAP: begin res = {value[HALF-1:0], value[DATA_W-1:HALF]}; carry = 1'b0;          end
            default: begin res = {1'b0, value[DATA_W-1:1]};             carry = value[0];        end
        endcase
    end

    // Flags: Z from the result except in accumulator mode; N and H cleared.
    always_comb begin
        fout.z = acc_mode ? 1'b0 : (res == '0);
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = carry;
    end
endmodule

// File: rtl/bitrot_bitop.sv
// Module: bitrot_bitop
// Single-bit test, clear and set. Assumes grp is one of the three bit groups
// whenever its outputs are used; otherwise it passes value and flags through.
module bitrot_bitop
    import bitrot_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  flags_t            fin,
    input  grp_e              grp,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] res,
    output flags_t            fout
);
    logic [DATA_W-1:0] mask;

    // One-hot mask built bit by bit from the index.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (bit_idx == IDX_W'(i));
    end

    // Apply the operation selected by the group.
    always_comb begin
        res  = value;
        fout = fin;
        unique case (grp)
            GRP_TEST: begin
                fout.z = ~|(value & mask);
                fout.n = 1'b0;
                fout.h = 1'b1;
            end
            GRP_CLR:  res = value & ~mask;
            GRP_SET:  res = value | mask;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bitrot_unit.sv
// Module: bitrot_unit (top)
// Combinational execution of the prefixed bit-manipulation opcode space plus
// the accumulator rotates. Assumes the caller supplies the operand read from
// reg_sel and commits result only when wr_en is high.
module bitrot_unit
    import bitrot_pkg::*;
(
    input  logic [7:0] sub_op,
    input  logic [7:0] operand,
    input  logic [3:0] flags_in,
    input  logic       acc_mode,
    output logic [7:0] result,
    output logic [3:0] flags_out,
    output logic       wr_en,
    output logic [2:0] reg_sel
);
    grp_e              grp;
    shop_e             shop;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] sh_res, bo_res;
    flags_t            sh_f, bo_f, fin;

    assign fin = flags_t'(flags_in);

    bitrot_decode u_dec (
        .sub_op(sub_op), .acc_mode(acc_mode), .grp(grp), .shop(shop),
        .bit_idx(bit_idx), .reg_sel(reg_sel), .wr_en(wr_en)
    );

    bitrot_shift u_sh (
        .value(operand), .fin(fin), .shop(shop), .acc_mode(acc_mode),
        .res(sh_res), .fout(sh_f)
    );

    bitrot_bitop u_bo (
        .value(operand), .fin(fin), .grp(grp), .bit_idx(bit_idx),
        .res(bo_res), .fout(bo_f)
    );

    // Output select between the shift path and the bit path.
    always_comb begin
        if (grp == GRP_SHIFT) begin
            result    = sh_res;
            flags_out = sh_f;
        end else begin
            result    = bo_res;
            flags_out = bo_f;
        end
    end
endmodule

// File: rtl/bitrot_unit_chk.sv
// Module: bitrot_unit_chk
// Port-level properties of bitrot_unit, attached through bind. Assumes inputs
// settle before evaluation; all checks are immediate on combinational values.
module bitrot_unit_chk (
    input logic [7:0] sub_op,
    input logic [7:0] operand,
    input logic [3:0] flags_in,
    input logic       acc_mode,
    input logic [7:0] result,
    input logic [3:0] flags_out,
    input logic       wr_en,
    input logic [2:0] reg_sel
);
    // Evaluate every property whenever a port value changes.
    always_comb begin
        if (acc_mode) begin
            a_r1_acc_reg: assert (reg_sel == 3'd7);
            a_r9_acc_flags: assert (flags_out[3:1] == 3'b000);
        end else begin
            a_r1_field_reg: assert (reg_sel == sub_op[2:0]);
            if (sub_op[7:6] == 2'b00) begin
                a_r6_zero_flag: assert (flags_out[3] == (result == 8'h00) && flags_out[2:1] == 2'b00);
            end
            if (sub_op[7:6] == 2'b01) begin
                a_r7_test_keeps: assert (result == operand && flags_out[1:0] == {1'b1, flags_in[0]} && !wr_en);
            end
            if (sub_op[7]) begin
                a_r8_flags_kept: assert (flags_out == flags_in);
                a_r8_single_bit: assert ($countones(result ^ operand) <= 1);
            end
        end
    end
endmodule

bind bitrot_unit bitrot_unit_chk u_chk (.*);

// File: tb/bitrot_unit_bench.sv
// Bench: directed corners plus seeded random vectors against a bench model.
module bitrot_unit_bench;
    logic       clk = 1'b0;
    logic [7:0] sub_op = '0, operand = '0;
    logic [3:0] flags_in = '0;
    logic       acc_mode = 1'b0;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       wr_en;
    logic [2:0] reg_sel;
    int checks = 0, fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bitrot_unit u_bitrot_unit (.*);

    // Expected {wr_en, reg_sel, flags, result} from the requirements.
    function automatic logic [15:0] model(logic [7:0] op, logic [7:0] x, logic [3:0] f, logic acc);
        logic [7:0] r;
        logic [3:0] fo;
        logic [2:0] code;
        logic cy;
        logic w;
        logic [2:0] rs;
        w  = 1'b1;
        rs = acc ? 3'd7 : op[2:0];
        fo = f;
        r  = x;
        code = acc ? {1'b0, op[4:3]} : op[5:3];
        if (acc || op[7:6] == 2'b00) begin
            case (code)
                3'd0: begin r = {x[6:0], x[7]}; cy = x[7]; end
                3'd1: begin r = {x[0], x[7:1]}; cy = x[0]; end
                3'd2: begin r = {x[6:0], f[0]}; cy = x[7]; end
                3'd3: begin r = {f[0], x[7:1]}; cy = x[0]; end
                3'd4: begin r = {x[6:0], 1'b0}; cy = x[7]; end
                3'd5: begin r = {x[7], x[7:1]}; cy = x[0]; end
                3'd6: begin r = {x[3:0], x[7:4]}; cy = 1'b0; end
                default: begin r = {1'b0, x[7:1]}; cy = x[0]; end
            endcase
            fo = {(!acc && r == 8'h00), 1'b0, 1'b0, cy};
        end else if (op[7:6] == 2'b01) begin
            w  = 1'b0;
            fo = {~x[op[5:3]], 1'b0, 1'b1, f[0]};
        end else begin
            r[op[5:3]] = op[6];
        end
        return {w, rs, fo, r};
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (op=%h x=%h f=%h acc=%b)",
                     tag, got, exp, sub_op, operand, flags_in, acc_mode);
        end
    endtask

    function automatic string tag_of(logic [7:0] op, logic acc);
        if (acc) return "R9";
        case (op[7:6])
            2'b00: begin
                if (op[5:3] == 3'd6) return "R5";
                if (op[5:3] < 3'd2)  return "R2";
                if (op[5:3] < 3'd4)  return "R3";
                return "R4";
            end
            2'b01: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(string tag, logic [7:0] op, logic [7:0] x, logic [3:0] f, logic acc);
        @(negedge clk);
        sub_op = op; operand = x; flags_in = f; acc_mode = acc;
        #1;
        check(tag, {wr_en, reg_sel, flags_out, result}, model(op, x, f, acc));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        // Idle inputs: rotate-left code on zero gives Z=1 (R6).
        #1;
        check("R6 idle", {wr_en, reg_sel, flags_out, result}, 16'h8800);
        apply("R2 rotate left 80", 8'h00, 8'h80, 4'h0, 1'b0);
        apply("R2 rotate right 01", 8'h09, 8'h01, 4'h0, 1'b0);
        apply("R3 rl carry in", 8'h10, 8'h00, 4'h1, 1'b0);
        apply("R3 rr to zero", 8'h1B, 8'h01, 4'h0, 1'b0);
        apply("R4 asr sign", 8'h28, 8'h81, 4'h0, 1'b0);
        apply("R4 lsr", 8'h38, 8'h81, 4'hF, 1'b0);
        apply("R4 asl", 8'h20, 8'h80, 4'h0, 1'b0);
        apply("R5 swap", 8'h30, 8'hF0, 4'hF, 1'b0);
        apply("R6 swap zero", 8'h37, 8'h00, 4'h7, 1'b0);
        apply("R7 test clear bit", 8'h78, 8'h7F, 4'h1, 1'b0);
        apply("R10 test no write", 8'h46, 8'h01, 4'h0, 1'b0);
        apply("R8 set bit0", 8'hC0, 8'hFE, 4'hA, 1'b0);
        apply("R8 clear bit7", 8'hBD, 8'hFF, 4'h5, 1'b0);
        apply("R1 reg field", 8'h05, 8'h12, 4'h0, 1'b0);
        apply("R9 acc zero result", 8'h00, 8'h00, 4'h0, 1'b1);
        apply("R9 acc with test opcode", 8'h4B, 8'h01, 4'h1, 1'b1);
        apply("R9 acc rr through carry", 8'hFF, 8'h01, 4'h0, 1'b1);
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op, x;
            logic [3:0] f;
            logic a;
            op = 8'($urandom);
            x  = 8'($urandom);
            f  = 4'($urandom);
            a  = ($urandom % 4) == 0;
            apply(tag_of(op, a), op, x, f, a);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule